// File: doc/BRIEF.md
# SMBus Serial EEPROM Target Array

This block is the storage side of one or more serial-EEPROM targets on a system management bus. A bit-level front end, which is not part of this block, decodes the bus traffic. It presents each target operation as a single-cycle event. The event carries a 7-bit target address, an operation code, a command byte, a data byte and a byte index within the current burst. Each instance of the memory holds 256 bytes and one 8-bit current-offset pointer.

A send-byte operation moves the pointer. A receive-byte operation streams bytes from the pointer. A write burst stores its bytes from the command value onward. A read burst takes its start point from the command on its first byte only, then streams from the pointer. The read burst has no length byte.

`NUM_DEV` instances answer consecutive bus addresses starting at `BASE_ADDR`. When `PRELOAD` is set, reset fills every array with an arithmetic pattern. Read results come back one cycle after the event, on a registered data port.

Top module: `smb_eeprom_array`

## Requirements
- R1: After reset, every pointer is 0 and `rd_valid` and `ack` are low. With `PRELOAD` set, byte k of instance d holds (k*PRE_MUL + d*PRE_ADD + PRE_OFS) mod 256.
- R2: A send-byte event (op 1) loads `ev_data` into the selected pointer and leaves the memory unchanged.
- R3: A receive-byte event (op 2) returns the byte at the pointer. It then advances the pointer by one, modulo 256, so 255 is followed by 0.
- R4: A write-data event (op 3) stores `ev_data` at (`ev_cmd` + `ev_idx`) mod 256. This lets a burst run past 255 into address 0. The pointer is unchanged.
- R5: A read-data event (op 4) with `ev_idx` 0 returns the byte at `ev_cmd` and sets the pointer to `ev_cmd`+1. With `ev_idx` nonzero it ignores `ev_cmd`, returns the byte at the pointer and advances the pointer.
- R6: A quick command (op 0) changes neither memory nor pointer and produces no read data.
- R7: Instance i answers only at address `BASE_ADDR`+i. Events at any other address change nothing, raise no `ack` and produce no read data.
- R8: `ack` and `rd_valid` rise in the cycle after an accepted event, and `rd_valid` only for ops 2 and 4. `rd_data` holds its value between read results.
- R9: An event at one instance leaves the memory and pointer of every other instance unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | One-cycle event strobe |
| ev_addr | input | 7 | Target bus address of the event |
| ev_op | input | 3 | 0 quick, 1 send byte, 2 receive byte, 3 write data, 4 read data |
| ev_cmd | input | 8 | Command byte (start offset of a burst) |
| ev_data | input | 8 | Data byte for send and write |
| ev_idx | input | 8 | Byte index within the current burst |
| ack | output | 1 | An instance accepted the previous cycle's event |
| rd_valid | output | 1 | `rd_data` carries a read result |
| rd_data | output | 8 | Registered read byte |

## Verification
Every result is due exactly one clock edge after the edge that accepts the event. This covers the read byte, `ack`, the pointer move and a memory store. The bench drives each event on a falling edge and holds it across one rising edge. It then samples the outputs at the next falling edge, so each event's own result is observed before the next event is applied. Effects on memory and the pointer are observed through later receive or read bursts against a model array computed from the preload formula and the requirements.

// File: rtl/smbe_pkg.sv
package smbe_pkg;
  typedef enum logic [2:0] {
    OP_QUICK = 3'd0,
    OP_SEND  = 3'd1,
    OP_RECV  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } smbe_op_e;
endpackage

// File: rtl/smbe_addr_dec.sv
module smbe_addr_dec #(
  parameter int NUM_DEV   = 2,
  parameter int ADDR_W    = 7,
  parameter int BASE_ADDR = 'h50
) (
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic [NUM_DEV-1:0] sel
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + i);
    assign sel[i] = ev_valid && (ev_addr == MY_ADDR);
  end
endmodule

// File: rtl/smbe_store.sv
module smbe_store
  import smbe_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DW      = 8,
  parameter int DEV_IDX = 0,
  parameter bit PRELOAD = 1'b1,
  parameter int PRE_MUL = 3,
  parameter int PRE_ADD = 64,
  parameter int PRE_OFS = 17,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  smbe_op_e      op,
  input  logic [AW-1:0] cmd,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] idx,
  output logic [DW-1:0] rd_byte
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q, ptr_n, rd_addr, wr_addr;
  logic          ptr_en, we;

  function automatic logic [DW-1:0] init_val(input int k);
    if (PRELOAD) return DW'(k * PRE_MUL + DEV_IDX * PRE_ADD + PRE_OFS);
    else         return '0;
  endfunction

  // address selection and next pointer
  always_comb begin
    rd_addr = (op == OP_READ && idx == '0) ? cmd : ptr_q;
    wr_addr = cmd + idx;
    we      = sel && (op == OP_WRITE);
    ptr_n   = ptr_q;
    ptr_en  = 1'b0;
    if (sel) begin
      unique case (op)
        OP_SEND: begin ptr_n = AW'(data);    ptr_en = 1'b1; end
        OP_RECV,
        OP_READ: begin ptr_n = rd_addr + 1'b1; ptr_en = 1'b1; end
        default: ;
      endcase
    end
  end

  assign rd_byte = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= init_val(k);
    end else if (we) begin
      mem[wr_addr] <= data;
    end
  end

  AST_SEND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_SEND) |=> ptr_q == AW'($past(data))); // R2
  AST_RECV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_RECV) |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R3
  AST_WRITE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_WRITE) |=> $stable(ptr_q)); // R4
  AST_READ_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_READ && idx == '0) |=> ptr_q == AW'($past(cmd) + 1'b1)); // R5
  AST_IDLE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || op == OP_QUICK) |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/smb_eeprom_array.sv
module smb_eeprom_array
  import smbe_pkg::*;
#(
  parameter int NUM_DEV   = 2,
  parameter int BASE_ADDR = 'h50,
  parameter int DEPTH     = 256,
  parameter int DW        = 8,
  parameter int ADDR_W    = 7,
  parameter bit PRELOAD   = 1'b1,
  parameter int PRE_MUL   = 3,
  parameter int PRE_ADD   = 64,
  parameter int PRE_OFS   = 17,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [2:0]        ev_op,
  input  logic [AW-1:0]     ev_cmd,
  input  logic [DW-1:0]     ev_data,
  input  logic [AW-1:0]     ev_idx,
  output logic              ack,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  smbe_op_e         op;
  logic [NUM_DEV-1:0] sel;
  logic [DW-1:0]    rd_byte [NUM_DEV];
  logic [DW-1:0]    rd_mux, rd_data_n;
  logic             any_hit, is_rd, rd_valid_n, ack_n;

  assign op = smbe_op_e'(ev_op);

  smbe_addr_dec #(
    .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .ev_valid(ev_valid), .ev_addr(ev_addr), .sel(sel)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    smbe_store #(
      .DEPTH(DEPTH), .DW(DW), .DEV_IDX(i), .PRELOAD(PRELOAD),
      .PRE_MUL(PRE_MUL), .PRE_ADD(PRE_ADD), .PRE_OFS(PRE_OFS)
    ) u_store (
      .clk(clk), .rst_n(rst_n), .sel(sel[i]), .op(op),
      .cmd(ev_cmd), .data(ev_data), .idx(ev_idx), .rd_byte(rd_byte[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (sel[i]) rd_mux = rd_mux | rd_byte[i];
    any_hit    = |sel;
    is_rd      = (op == OP_RECV) || (op == OP_READ);
    ack_n      = any_hit;
    rd_valid_n = any_hit && is_rd;
    rd_data_n  = rd_valid_n ? rd_mux : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      ack      <= ack_n;
      rd_valid <= rd_valid_n;
      rd_data  <= rd_data_n;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R7
  AST_RDV_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(ev_valid && (ev_op == 3'd2 || ev_op == 3'd4))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && (ev_op == 3'd2 || ev_op == 3'd4)) |=> $stable(rd_data)); // R8
  AST_RDV_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ack); // R7
endmodule

// File: tb/smb_eeprom_array_bench.sv
module smb_eeprom_array_bench;
  localparam int BASE = 'h50;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [6:0] ev_addr = '0;
  logic [2:0] ev_op = '0;
  logic [7:0] ev_cmd = '0, ev_data = '0, ev_idx = '0;
  logic ack, rd_valid;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [2][256];

  always #4 clk = ~clk;

  smb_eeprom_array #(.NUM_DEV(2), .BASE_ADDR(BASE), .PRELOAD(1'b1),
    .PRE_MUL(3), .PRE_ADD(64), .PRE_OFS(17)) u_smb_eeprom_array (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .ev_op(ev_op), .ev_cmd(ev_cmd), .ev_data(ev_data), .ev_idx(ev_idx),
    .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one event; returns at the falling edge after the accepting edge
  task automatic ev(input int a, input int op, input int c, input int d, input int i);
    @(negedge clk);
    ev_addr = 7'(a); ev_op = 3'(op); ev_cmd = 8'(c); ev_data = 8'(d); ev_idx = 8'(i);
    ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic expect_rd(input int exp, input string req);
    chk(rd_valid === 1'b1 && rd_data === 8'(exp), req, rd_data, exp);
  endtask

  initial begin
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 256; k++) model[d][k] = 8'(k * 3 + d * 64 + 17);
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0 && ack === 1'b0, "R1 reset outputs", {ack, rd_valid}, 0);
    rst_n = 1'b1;

    // R1 R3: full receive sweep from reset pointer, plus wrap
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 256; k++) begin
        ev(BASE + d, 2, 0, 0, 0);
        expect_rd(model[d][k], "R1 R3 preload sweep");
      end
      ev(BASE + d, 2, 0, 0, 0);
      expect_rd(model[d][0], "R3 pointer wrap 255->0");
    end

    // R2: send byte moves pointer, memory untouched
    ev(BASE, 1, 0, 'h80, 0);
    chk(ack === 1'b1 && rd_valid === 1'b0, "R2 R8 send ack no data", {ack, rd_valid}, 2);
    ev(BASE, 2, 0, 0, 0);
    expect_rd(model[0]['h80], "R2 send sets pointer");

    // R4: wrapping write burst leaves pointer alone
    ev(BASE + 1, 1, 0, 'h10, 0);
    for (int j = 0; j < 6; j++) begin
      ev(BASE + 1, 3, 'hFD, 'hA0 + j, j);
      model[1][(('hFD + j) & 255)] = 8'('hA0 + j);
      chk(rd_valid === 1'b0 && ack === 1'b1, "R4 R8 write no data", {ack, rd_valid}, 2);
    end
    ev(BASE + 1, 2, 0, 0, 0);
    expect_rd(model[1]['h10], "R4 pointer kept across write");

    // R5: read burst from command, then pointer continues
    for (int j = 0; j < 6; j++) begin
      ev(BASE + 1, 4, 'hFD, 0, j);
      expect_rd(model[1][('hFD + j) & 255], "R4 R5 read back wrapped burst");
    end
    ev(BASE + 1, 2, 0, 0, 0);
    expect_rd(model[1][3], "R5 pointer after burst");
    ev(BASE, 4, 'h20, 0, 0);
    expect_rd(model[0]['h20], "R5 first byte from cmd");
    ev(BASE, 4, 'h99, 0, 1);
    expect_rd(model[0]['h21], "R5 later byte ignores cmd");

    // R6: quick command
    ev(BASE, 0, 'h55, 'h66, 0);
    chk(ack === 1'b1 && rd_valid === 1'b0, "R6 quick ack no data", {ack, rd_valid}, 2);
    ev(BASE, 2, 0, 0, 0);
    expect_rd(model[0]['h22], "R6 quick keeps pointer");

    // R7: unmatched address
    ev(BASE + 2, 3, 0, 'hEE, 0);
    chk(ack === 1'b0 && rd_valid === 1'b0, "R7 foreign write ignored", {ack, rd_valid}, 0);
    ev(BASE + 2, 4, 0, 0, 0);
    chk(ack === 1'b0 && rd_valid === 1'b0, "R7 foreign read ignored", {ack, rd_valid}, 0);
    ev(BASE - 1, 1, 0, 'h00, 0);
    chk(ack === 1'b0, "R7 address below base", ack, 0);
    ev(BASE, 2, 0, 0, 0);
    expect_rd(model[0]['h23], "R7 pointer untouched by foreign");

    // R9: write to instance 0 does not reach instance 1
    ev(BASE, 3, 'h40, 'h5A, 0);
    model[0]['h40] = 8'h5A;
    ev(BASE + 1, 4, 'h40, 0, 0);
    expect_rd(model[1]['h40], "R9 other instance unchanged");

    // final read-burst sweep of both arrays
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 256; k++) begin
        ev(BASE + d, 4, 0, 0, k);
        expect_rd(model[d][k], "R4 R7 R9 final contents");
      end

    // R8: rd_data held while idle
    repeat (2) @(negedge clk);
    chk(rd_valid === 1'b0 && rd_data === model[1][255], "R8 idle hold",
        rd_data, model[1][255]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule